// File: doc/BRIEF.md
# Pipelined Synchronous Read Output Stage

This block is the read side of the data pins of a synchronous, pipelined burst memory. When the access logic asserts its read strobe, the word the array presents in that same cycle is captured into an output register on the next rising clock edge. The word then sits on the bidirectional bus for the following cycle. A pipelined select flag tracks whether the device is selected. An asynchronous active-low output enable and an asynchronous sleep request gate the per-bit drive enables directly, with no clock involved.

The select flag only changes at clock edges. A deselect strobe clears it, and the outputs go undriven one clock later. A read strobe while deselected sets the flag again. That first cycle after reselection is always high impedance, whatever the output enable says. Cycles without a read strobe, writes included, leave the bus undriven in the following cycle. The 36-bit bus is made of four identical 9-bit lanes, each holding 8 data bits and 1 parity bit.

Top module: `rd_out_stage`

## Requirements
- R1: A word on `arr_data_i` with `rd_strobe_i` high in cycle n appears on `bus_o` in cycle n+1, with all drive enables high. This holds when the device is selected, `oe_ni` is low, `sleep_i` is low, and cycle n+1 is not the first cycle after reselection.
- R2: Read strobes on back-to-back cycles each return their own word exactly one cycle later, with no gaps and no repeats.
- R3: While `oe_ni` is high, every drive enable is low. When `oe_ni` returns low, driving resumes in the same cycle with the held word and no clock edge needed.
- R4: If a read strobe arrives while the device is deselected, the next cycle is high impedance even with `oe_ni` low. A read strobe in that forced cycle is driven normally in the cycle after.
- R5: If `desel_i` is high in cycle n, all drive enables are low in cycle n+1. Deselect takes priority over a read strobe in the same cycle.
- R6: If a cycle has `rd_strobe_i` low (idle or write), all drive enables are low in the next cycle.
- R7: While `sleep_i` is high, every drive enable is low, asynchronously. Releasing it restores the held read data in the same cycle.
- R8: After `rst_ni` is asserted, all drive enables are low and the device counts as deselected, so the first read after reset is a forced high-impedance cycle.
- R9: All 36 drive enables always carry the same value. Lane l occupies bits [9l+8:9l], with bit 9l+8 as its parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_strobe_i | input | 1 | Read access registered for this cycle; array data valid |
| desel_i | input | 1 | Deselect registered for this cycle |
| sleep_i | input | 1 | Sleep request, asynchronous, active high |
| oe_ni | input | 1 | Output enable, asynchronous, active low |
| arr_data_i | input | 36 | Word read from the array |
| bus_o | output | 36 | Value for the bus pads |
| drive_en_o | output | 36 | Per-bit pad drive enable |

## Verification
The bench covers several read patterns:
- A lone read after reset or deselect, which separates the forced high-impedance reselect cycle from a normal one-cycle-latency read.
- A run of back-to-back reads with distinct per-lane words, which shows that no word is dropped, repeated or shifted by a cycle.
- Output-enable and sleep toggles in the middle of a held word, checked without a clock edge, which separate the asynchronous gating from the clocked pipeline.
- Idle cycles, and a deselect issued together with a read, which show that only a read strobe arms the drivers and that deselect wins.

// File: rtl/rd_out_pkg.sv
package rd_out_pkg;
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned LANE_W_DEF = 9;
endpackage

// File: rtl/rd_out_reg.sv
module rd_out_reg #(
  parameter int unsigned LANES  = rd_out_pkg::LANES_DEF,
  parameter int unsigned LANE_W = rd_out_pkg::LANE_W_DEF,
  localparam int unsigned BUS_W = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_strobe_i,
  input  logic [BUS_W-1:0] arr_data_i,
  output logic [BUS_W-1:0] data_o,
  output logic             rd_vld_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_q <= '0;
      else if (rd_strobe_i) lane_q <= arr_data_i[l*LANE_W +: LANE_W];
    end
    assign data_o[l*LANE_W +: LANE_W] = lane_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_vld_o <= 1'b0;
    else         rd_vld_o <= rd_strobe_i;
  end

  // R1 / R2: captured word equals the word offered with the strobe
  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i |=> (data_o == $past(arr_data_i)));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_strobe_i |=> $stable(data_o));
endmodule

// File: rtl/rd_sel_track.sv
module rd_sel_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_strobe_i,
  input  logic desel_i,
  output logic sel_o,
  output logic fresh_o
);
  logic sel_q, fresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= rd_strobe_i & ~desel_i & ~sel_q;
      if (desel_i)          sel_q <= 1'b0;
      else if (rd_strobe_i) sel_q <= 1'b1;
    end
  end

  assign sel_o   = sel_q;
  assign fresh_o = fresh_q;

  // R5: deselect always leaves the flag clear
  p_desel_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel_i |=> !sel_o);
  // R4: fresh cycle only right after a deselected-to-selected move
  p_fresh_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fresh_o |-> (sel_o && !$past(sel_o)));
endmodule

// File: rtl/rd_drive_ctl.sv
module rd_drive_ctl #(
  parameter int unsigned BUS_W = rd_out_pkg::LANES_DEF * rd_out_pkg::LANE_W_DEF
) (
  input  logic             rd_vld_i,
  input  logic             sel_i,
  input  logic             fresh_i,
  input  logic             oe_ni,
  input  logic             sleep_i,
  output logic [BUS_W-1:0] drive_en_o
);
  logic pipe_en;
  assign pipe_en = rd_vld_i & sel_i & ~fresh_i;

  // async gating: output enable and sleep act without a clock
  always_comb drive_en_o = {BUS_W{pipe_en & ~oe_ni & ~sleep_i}};
endmodule

// File: rtl/rd_out_stage.sv
module rd_out_stage #(
  parameter int unsigned LANES  = rd_out_pkg::LANES_DEF,
  parameter int unsigned LANE_W = rd_out_pkg::LANE_W_DEF,
  localparam int unsigned BUS_W = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_strobe_i,
  input  logic             desel_i,
  input  logic             sleep_i,
  input  logic             oe_ni,
  input  logic [BUS_W-1:0] arr_data_i,
  output logic [BUS_W-1:0] bus_o,
  output logic [BUS_W-1:0] drive_en_o
);
  logic rd_vld, sel, fresh;

  rd_out_reg #(.LANES(LANES), .LANE_W(LANE_W)) u_reg (
    .clk_i, .rst_ni, .rd_strobe_i, .arr_data_i,
    .data_o(bus_o), .rd_vld_o(rd_vld)
  );

  rd_sel_track u_sel (
    .clk_i, .rst_ni, .rd_strobe_i, .desel_i,
    .sel_o(sel), .fresh_o(fresh)
  );

  rd_drive_ctl #(.BUS_W(BUS_W)) u_drv (
    .rd_vld_i(rd_vld), .sel_i(sel), .fresh_i(fresh),
    .oe_ni, .sleep_i, .drive_en_o
  );

  p_oe_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (drive_en_o == '0));
  p_reselect_hiz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && !desel_i && !sel) |=> (drive_en_o == '0));
  p_desel_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel_i |=> (drive_en_o == '0));
  p_no_read_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_strobe_i |=> (drive_en_o == '0));
  p_sleep_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (drive_en_o == '0));
  p_uniform_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_o == '0) || (drive_en_o == '1));
endmodule

// File: tb/tb_rd_out_stage.sv
module tb_rd_out_stage;
  localparam int W = 36;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic rd_strobe_i = 1'b0, desel_i = 1'b0, sleep_i = 1'b0, oe_ni = 1'b0;
  logic [W-1:0] arr_data_i = '0;
  logic [W-1:0] bus_o, drive_en_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rd_out_stage dut (.clk_i(clk), .rst_ni, .rd_strobe_i, .desel_i, .sleep_i,
                    .oe_ni, .arr_data_i, .bus_o, .drive_en_o);

  task automatic chk(input string tag, input bit exp_on, input logic [W-1:0] exp_d);
    logic [W-1:0] exp_en;
    exp_en = exp_on ? '1 : '0;
    n_chk++;
    if (drive_en_o !== exp_en) begin
      n_bad++;
      $display("FAIL %s drive_en act=%h exp=%h", tag, drive_en_o, exp_en);
    end else if (exp_on && bus_o !== exp_d) begin
      n_bad++;
      $display("FAIL %s bus act=%h exp=%h", tag, bus_o, exp_d);
    end
  endtask

  // one clock: apply inputs, step past the edge
  task automatic cyc(input bit rd, input bit ds, input logic [W-1:0] d);
    rd_strobe_i = rd; desel_i = ds; arr_data_i = d;
    @(posedge clk); #1;
    rd_strobe_i = 1'b0; desel_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R8 reset", 0, '0);
    cyc(1, 0, 36'h1_1111_1111);
    chk("R8 first read after reset forced hiz", 0, '0);
  endtask

  task automatic t_latency;
    cyc(1, 0, 36'h9_A5A5_0F0F);
    chk("R1 one cycle latency", 1, 36'h9_A5A5_0F0F);
    chk("R9 lane parity bit", 1, 36'h9_A5A5_0F0F);
  endtask

  task automatic t_b2b;
    logic [W-1:0] w [4];
    w[0] = 36'h0_0102_0304; w[1] = 36'hF_FEFD_FCFB;
    w[2] = 36'h5_5555_5555; w[3] = 36'hA_AAAA_AAAA;
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, w[i]);
      chk($sformatf("R2 back-to-back word %0d", i), 1, w[i]);
    end
  endtask

  task automatic t_oe_mid;
    cyc(1, 0, 36'h3_1234_5678);
    chk("R1 burst word", 1, 36'h3_1234_5678);
    rd_strobe_i = 1'b1; arr_data_i = 36'h6_8765_4321;
    oe_ni = 1'b1; #1;
    chk("R3 oe high mid burst", 0, '0);
    oe_ni = 1'b0; #1;
    chk("R3 oe low again same cycle", 1, 36'h3_1234_5678);
    @(posedge clk); #1; rd_strobe_i = 1'b0;
    chk("R3 burst continues", 1, 36'h6_8765_4321);
  endtask

  task automatic t_idle;
    cyc(0, 0, 36'hC_CCCC_CCCC);
    chk("R6 no read strobe", 0, '0);
    cyc(1, 0, 36'h2_2222_2222);
    chk("R6 read after idle", 1, 36'h2_2222_2222);
  endtask

  task automatic t_desel;
    cyc(1, 1, 36'h7_7777_7777);
    chk("R5 deselect wins over read", 0, '0);
    cyc(1, 0, 36'h8_0000_0001);
    oe_ni = 1'b0; #1;
    chk("R4 reselect forced hiz", 0, '0);
    cyc(1, 0, 36'h1_F00D_BEEF);
    chk("R4 second read after reselect driven", 1, 36'h1_F00D_BEEF);
  endtask

  task automatic t_sleep;
    sleep_i = 1'b1; #1;
    chk("R7 sleep high", 0, '0);
    sleep_i = 1'b0; #1;
    chk("R7 sleep released", 1, 36'h1_F00D_BEEF);
  endtask

  initial begin
    fork
      begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none
    #1;
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    rst_ni = 1'b1;
    @(posedge clk); #1;
    t_reset;
    t_latency;
    t_b2b;
    t_oe_mid;
    t_idle;
    t_desel;
    t_sleep;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule